// File: doc/BRIEF.md
# Upper-Memory Shadow Region Decoder

This block sits on the CPU memory path of a system controller. For every access to the first megabyte it decides whether the access is served by on-board DRAM or passed on to the external expansion bus. The decision depends only on the 20-bit address, the direction of the access and a handful of configuration bits. No clock or register is involved.

The range from C0000h to FFFFFh is divided into eight 32 KB segments. Each segment has its own enable bit. Two shared control bits apply to every enabled segment: one sends reads to DRAM, and one write-protects the segment so that writes go to the bus. A separate bit maps the 128 KB window from A0000h to BFFFFh into DRAM for both directions. Memory below A0000h always stays internal.

Two status flags report whether the system BIOS area is shadowed. This area is the segments at or above E0000h. The flags are computed from the configuration alone.

Top module: `shadow_decoder`

## Requirements
- R1: Any address below A0000h raises readInternal on a read and writeInternal on a write, whatever the configuration.
- R2: With vgaMapEn = 1, addresses A0000h–BFFFFh are internal for both reads and writes.
- R3: With vgaMapEn = 0, addresses A0000h–BFFFFh are external for both reads and writes (both strobes low).
- R4: Segment i covers C0000h + i×8000h up to C0000h + i×8000h + 7FFFh, and only bit i of segEnable affects it.
- R5: In an enabled segment a read is internal exactly when shadowCtrl[1] = 1.
- R6: In an enabled segment a write is internal exactly when shadowCtrl[0] = 0; shadowCtrl[0] = 1 write-protects it, so writes go external.
- R7: In a segment whose enable bit is 0, both reads and writes are external, whatever shadowCtrl holds.
- R8: biosShadowRd is 1 exactly when some enabled segment among 4..7 (E0000h and up) exists and shadowCtrl[1] = 1, independent of the address.
- R9: biosShadowWr is 1 exactly when some enabled segment among 4..7 exists and shadowCtrl[0] = 0, independent of the address.
- R10: readInternal is never 1 while isWrite = 1, and writeInternal is never 1 while isWrite = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 20 | CPU memory address |
| isWrite | input | 1 | 1 = write access, 0 = read access |
| segEnable | input | 8 | Per-segment shadow enable, bit i for segment i |
| shadowCtrl | input | 2 | Bit 1: reads from DRAM; bit 0: write protect |
| vgaMapEn | input | 1 | Map A0000h–BFFFFh into DRAM |
| readInternal | output | 1 | Current read is served by DRAM |
| writeInternal | output | 1 | Current write is served by DRAM |
| biosShadowRd | output | 1 | BIOS area read from DRAM |
| biosShadowWr | output | 1 | BIOS area written to DRAM |

## Verification
The bench targets the region edges 9FFFFh/A0000h, BFFFFh/C0000h, DFFFFh/E0000h and FFFFFh, plus the first and last byte of each segment. An off-by-one comparison there would route a single 32 KB or 128 KB edge to the wrong side. Each segment is enabled on its own to catch a swapped or shifted enable bit, which would shadow the wrong segment. The write-protect bit is checked for its inverted sense, where an error would make writes reach DRAM while reads did not. The BIOS flags are checked with only low segments enabled, to catch flags that wrongly include C0000h–DFFFFh.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int ADDR_W   = 20;
  localparam int NSEG     = 8;
  localparam int SEG_SIZE = 32'h8000;
  localparam int SEG_BASE = 32'hC0000;
  localparam int VGA_BASE = 32'hA0000;
  localparam int VGA_SIZE = 32'h20000;
  localparam int BIOS_FIRST = NSEG / 2;

  typedef struct packed {
    logic            lowHit;
    logic            vgaHit;
    logic [NSEG-1:0] segHit;
  } regionHit_t;
endpackage

// File: rtl/shadow_region_ctrl.sv
module shadow_region_ctrl
  import shadow_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output regionHit_t        hit
);
  localparam logic [ADDR_W-1:0] VGA_LO = ADDR_W'(VGA_BASE);
  localparam logic [ADDR_W-1:0] VGA_HI = ADDR_W'(VGA_BASE + VGA_SIZE - 1);

  always_comb begin
    hit.lowHit = (addr < VGA_LO);
    hit.vgaHit = (addr >= VGA_LO) && (addr <= VGA_HI);
  end

  for (genvar i = 0; i < NSEG; i++) begin : gSeg
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(SEG_BASE + i * SEG_SIZE);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(SEG_BASE + (i + 1) * SEG_SIZE - 1);
    assign hit.segHit[i] = (addr >= LO) && (addr <= HI);
  end

  always_comb begin
    // R4: at most one region claims an address
    a_r4_one_region: assert ($onehot0({hit.lowHit, hit.vgaHit, hit.segHit}))
      else $error("R4: overlapping regions");
  end
endmodule

// File: rtl/shadow_route_dp.sv
module shadow_route_dp
  import shadow_pkg::*;
(
  input  regionHit_t      hit,
  input  logic            isWrite,
  input  logic [NSEG-1:0] segEnable,
  input  logic [1:0]      shadowCtrl,
  input  logic            vgaMapEn,
  output logic            readInternal,
  output logic            writeInternal,
  output logic            biosShadowRd,
  output logic            biosShadowWr
);
  logic readFromDram;
  logic writeProtect;
  logic [NSEG-1:0] segRd;
  logic [NSEG-1:0] segWr;
  logic rdRoute;
  logic wrRoute;
  logic biosAny;

  assign readFromDram = shadowCtrl[1];
  assign writeProtect = shadowCtrl[0];

  for (genvar i = 0; i < NSEG; i++) begin : gRoute
    assign segRd[i] = hit.segHit[i] & segEnable[i] & readFromDram;
    assign segWr[i] = hit.segHit[i] & segEnable[i] & ~writeProtect;
  end

  assign rdRoute = hit.lowHit | (hit.vgaHit & vgaMapEn) | (|segRd);
  assign wrRoute = hit.lowHit | (hit.vgaHit & vgaMapEn) | (|segWr);

  assign readInternal  = rdRoute & ~isWrite;
  assign writeInternal = wrRoute & isWrite;

  assign biosAny      = |segEnable[NSEG-1:BIOS_FIRST];
  assign biosShadowRd = biosAny & readFromDram;
  assign biosShadowWr = biosAny & ~writeProtect;

  always_comb begin
    a_r1_low_internal: assert (!hit.lowHit || readInternal || writeInternal)
      else $error("R1: low memory not internal");
    a_r3_vga_off_external: assert (!(hit.vgaHit && !vgaMapEn) || !(readInternal || writeInternal))
      else $error("R3: vga window routed internal");
    a_r7_disabled_external: assert (!((|hit.segHit) && !(|(hit.segHit & segEnable)))
                                    || !(readInternal || writeInternal))
      else $error("R7: disabled segment routed internal");
    a_r10_direction: assert (!(readInternal && writeInternal))
      else $error("R10: both strobes high");
  end
endmodule

// File: rtl/shadow_decoder.sv
module shadow_decoder
  import shadow_pkg::*;
(
  input  logic [19:0] addr,
  input  logic        isWrite,
  input  logic [7:0]  segEnable,
  input  logic [1:0]  shadowCtrl,
  input  logic        vgaMapEn,
  output logic        readInternal,
  output logic        writeInternal,
  output logic        biosShadowRd,
  output logic        biosShadowWr
);
  regionHit_t hit;

  shadow_region_ctrl u_ctrl (
    .addr (addr),
    .hit  (hit)
  );

  shadow_route_dp u_dp (
    .hit           (hit),
    .isWrite       (isWrite),
    .segEnable     (segEnable),
    .shadowCtrl    (shadowCtrl),
    .vgaMapEn      (vgaMapEn),
    .readInternal  (readInternal),
    .writeInternal (writeInternal),
    .biosShadowRd  (biosShadowRd),
    .biosShadowWr  (biosShadowWr)
  );
endmodule

// File: tb/sim_shadow_decoder.sv
`timescale 1ns/1ps
module sim_shadow_decoder;
  logic clk = 0;
  always #10 clk = ~clk;

  logic [19:0] addr = '0;
  logic isWrite = 0;
  logic [7:0] segEnable = '0;
  logic [1:0] shadowCtrl = '0;
  logic vgaMapEn = 0;
  logic readInternal, writeInternal, biosShadowRd, biosShadowWr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  shadow_decoder u0 (.*);

  // Expected routing from the requirements
  function automatic bit expInternal(input logic [19:0] a, input bit wr);
    if (a < 20'hA0000) return 1;                                  // R1
    if (a < 20'hC0000) return vgaMapEn;                           // R2, R3
    begin
      int s = (int'(a) - 32'hC0000) / 32'h8000;                   // R4
      if (!segEnable[s]) return 0;                                // R7
      return wr ? !shadowCtrl[0] : shadowCtrl[1];                 // R5, R6
    end
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h wr=%0d en=%h ctrl=%b vga=%0d got=%0b exp=%0b",
               req, addr, isWrite, segEnable, shadowCtrl, vgaMapEn, got, exp);
    end
  endtask

  task automatic access(input string req, input logic [19:0] a, input bit wr);
    @(negedge clk);
    addr = a; isWrite = wr;
    #2;
    if (wr) begin
      chk(req, writeInternal, expInternal(a, 1));
      chk({req, "/R10"}, readInternal, 1'b0);
    end else begin
      chk(req, readInternal, expInternal(a, 0));
      chk({req, "/R10"}, writeInternal, 1'b0);
    end
  endtask

  task automatic tLowMemory;
    segEnable = '0; shadowCtrl = 2'b01; vgaMapEn = 0;
    access("R1", 20'h00000, 0); access("R1", 20'h00000, 1);
    access("R1", 20'h9FFFF, 0); access("R1", 20'h9FFFF, 1);
    access("R1", 20'h5A5A5, 1);
  endtask

  task automatic tVgaWindow;
    segEnable = 8'hFF; shadowCtrl = 2'b10;
    vgaMapEn = 1;
    access("R2", 20'hA0000, 0); access("R2", 20'hA0000, 1);
    access("R2", 20'hBFFFF, 0); access("R2", 20'hBFFFF, 1);
    vgaMapEn = 0;
    access("R3", 20'hA0000, 0); access("R3", 20'hB1234, 1);
    access("R3", 20'hBFFFF, 0); access("R3", 20'hBFFFF, 1);
    access("R1", 20'h9FFFF, 1);
  endtask

  task automatic tSegmentMap;
    vgaMapEn = 0; shadowCtrl = 2'b10;
    for (int i = 0; i < 8; i++) begin
      segEnable = 8'(1 << i);
      for (int j = 0; j < 8; j++) begin
        access("R4", 20'(32'hC0000 + j * 32'h8000), 0);
        access("R4", 20'(32'hC0000 + j * 32'h8000 + 32'h7FFF), 1);
      end
    end
  endtask

  task automatic tControlBits;
    segEnable = 8'hFF; vgaMapEn = 0;
    for (int c = 0; c < 4; c++) begin
      shadowCtrl = 2'(c);
      access("R5", 20'hC4000, 0); access("R5", 20'hF8000, 0);
      access("R6", 20'hC4000, 1); access("R6", 20'hFFFFF, 1);
    end
  endtask

  task automatic tDisabled;
    segEnable = 8'h00; vgaMapEn = 1;
    for (int c = 0; c < 4; c++) begin
      shadowCtrl = 2'(c);
      access("R7", 20'hC0000, 0); access("R7", 20'hDFFFF, 1);
      access("R7", 20'hE0000, 0); access("R7", 20'hFFFFF, 1);
    end
    segEnable = 8'h55;
    shadowCtrl = 2'b10;
    access("R7", 20'hC8000, 0); access("R7", 20'hC8000, 1);
  endtask

  task automatic tBiosFlags;
    for (int e = 0; e < 256; e += 17) begin
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        segEnable = 8'(e); shadowCtrl = 2'(c); addr = 20'h12345;
        #2;
        chk("R8", biosShadowRd, (|segEnable[7:4]) && shadowCtrl[1]);
        chk("R9", biosShadowWr, (|segEnable[7:4]) && !shadowCtrl[0]);
      end
    end
    @(negedge clk);
    segEnable = 8'h0F; shadowCtrl = 2'b10; addr = 20'hF0000;
    #2;
    chk("R8", biosShadowRd, 1'b0);
    chk("R9", biosShadowWr, 1'b0);
    segEnable = 8'h10; #2;
    chk("R8", biosShadowRd, 1'b1);
    chk("R9", biosShadowWr, 1'b1);
  endtask

  initial begin
    #1;
    chk("R1", readInternal, 1'b1);
    chk("R10", writeInternal, 1'b0);
    tLowMemory();
    tVgaWindow();
    tSegmentMap();
    tControlBits();
    tDisabled();
    tBiosFlags();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule